// File: doc/BRIEF.md
# Asynchronous DRAM Strobe Sequencer with CAS-before-RAS Refresh

This controller sits between a simple request/acknowledge host port and a conventional asynchronous DRAM whose row and column addresses share one set of address pins. A host address of twice the pin width is split: the upper half selects the row, the lower half the column. For each access the block presents the row, pulls the active-low row strobe, then presents the column and pulls the active-low column strobe. All delays are expressed as clock-cycle counts derived from nanosecond parameters and a clock-period parameter.

When the host presents another request to the same row in the cycle its acknowledge is high, the row stays open and only the column strobe toggles (page mode), up to a parameterised number of accesses per row opening. A periodic timer requests refresh cycles of the column-before-row kind, which need no external address because the memory steps its own row counter. A pending refresh takes precedence over host work as soon as the current column access has finished. The data bus is modelled as separate in and out buses plus an output enable.

Top module: `dram_seq_ctrl`

## Requirements
- R1: While reset is held, `ras_n`, `cas_n` and `we_n` are high, `dq_oe`, `host_ack` and `host_busy` are low.
- R2: For a host access, `dram_addr` carries `host_addr[2*AW-1:AW]` and stays unchanged from the cycle before `ras_n` falls; it then carries `host_addr[AW-1:0]`, unchanged from the cycle before `cas_n` falls.
- R3: A read returns on `host_rdata`, in the cycle `host_ack` is high, the value on `dq_in` sampled CAS_C clocks after `cas_n` fell, where CAS_C is the column access time rounded up to whole clocks.
- R4: Writes are early writes: `we_n` goes low (1 = read, 0 = write) before `cas_n` falls and is unchanged at that fall, `dq_out` equals the host write data and `dq_oe` is high; `dq_oe` is never high while `we_n` is high.
- R5: Two falls of `ras_n` are at least the row cycle time apart, rounded up to clocks (11 clocks for 110 ns at 10 ns).
- R6: A same-row request presented in the `host_ack` cycle is served with `ras_n` held low and only `cas_n` toggled; successive `cas_n` falls are at least the page cycle time apart (4 clocks for 35 ns at 10 ns).
- R7: A request to another row, or no request, closes the row; `ras_n` then stays high for at least the precharge time (5 clocks for 50 ns at 10 ns).
- R8: With no host traffic, a refresh starts every REF_WINDOW_NS / ROWS / CLK_NS clocks; in it `cas_n` falls at least one clock before `ras_n` and `we_n` stays high.
- R9: A pending refresh ends any page run and is served before a waiting host request, so the spacing of refreshes under traffic exceeds the idle spacing by no more than one access.
- R10: No more than PAGE_MAX column accesses occur within one low period of `ras_n`.
- R11: `host_ack` is high for exactly one clock per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request valid; held until `host_ack` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2*AW | Upper half row, lower half column |
| host_wdata | input | DW | Write data |
| host_busy | output | 1 | Sequencer not idle |
| host_ack | output | 1 | One-clock completion pulse |
| host_rdata | output | DW | Read data, valid with `host_ack` |
| dram_addr | output | AW | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DW | Data toward memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | DW | Data from memory |

## Verification
The bench drives same-row bursts, row changes inside a held request, runs longer than the page limit and a stream that straddles a refresh. A sequencer that moved the address in the strobe edge cycle would latch the wrong row or column and read back mismatching data; one that raised write enable late would produce a read-modify cycle with the bus enabled. A controller that let page runs continue past a pending refresh stretches the refresh spacing well beyond one access, and one that skipped the page limit shows more column falls per row opening than allowed. Missing precharge shows as a row strobe high for too few clocks between openings.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_RCD,
        ST_COL,
        ST_CAS,
        ST_CPRE,
        ST_REFC,
        ST_REFR,
        ST_PRE
    } seq_st_e;

    // nanoseconds to whole clocks, rounded up
    function automatic int ns2cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int INT_C = 390
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic pend_o
);
    localparam int CW = $clog2(INT_C);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          pend_q;
    logic          pend_d;
    logic          tick;

    always_comb begin
        tick   = (cnt_q == CW'(INT_C - 1));
        cnt_d  = tick ? '0 : cnt_q + 1'b1;
        pend_d = tick | (pend_q & ~start_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

    // a new period must never find the previous refresh still unserved
    assert_refresh_not_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pend_q) |-> start_i);

    assert_start_only_when_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> pend_q);

endmodule

// File: rtl/row_hit_cmp.sv
module row_hit_cmp #(
    parameter int AW = 11
) (
    input  logic [AW-1:0] open_row_i,
    input  logic [AW-1:0] new_row_i,
    output logic          hit_o
);
    assign hit_o = (open_row_i == new_row_i);
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
    import dram_seq_pkg::*;
#(
    parameter int AW            = 11,
    parameter int DW            = 16,
    parameter int CLK_NS        = 10,
    parameter int T_RCD_NS      = 20,
    parameter int T_CAC_NS      = 15,
    parameter int T_PC_NS       = 35,
    parameter int T_RC_NS       = 110,
    parameter int T_RAS_NS      = 60,
    parameter int T_RP_NS       = 50,
    parameter int REF_WINDOW_NS = 8000000,
    parameter int ROWS          = 2048,
    parameter int PAGE_MAX      = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_req,
    input  logic            host_we,
    input  logic [2*AW-1:0] host_addr,
    input  logic [DW-1:0]   host_wdata,
    output logic            host_busy,
    output logic            host_ack,
    output logic [DW-1:0]   host_rdata,
    output logic [AW-1:0]   dram_addr,
    output logic            dram_ras_n,
    output logic            dram_cas_n,
    output logic            dram_we_n,
    output logic [DW-1:0]   dram_dq_out,
    output logic            dram_dq_oe,
    input  logic [DW-1:0]   dram_dq_in
);
    localparam int RCD_C    = imax(1, ns2cyc(T_RCD_NS, CLK_NS));
    localparam int CAS_C    = imax(1, ns2cyc(T_CAC_NS, CLK_NS));
    localparam int PC_C     = ns2cyc(T_PC_NS, CLK_NS);
    localparam int CP_C     = imax(1, PC_C - CAS_C - 1);
    localparam int RLOW_C   = RCD_C + 1 + CAS_C + CP_C;
    localparam int RC_C     = ns2cyc(T_RC_NS, CLK_NS);
    localparam int REFLOW_C = imax(ns2cyc(T_RAS_NS, CLK_NS), RLOW_C);
    localparam int RP_C     = imax(imax(1, ns2cyc(T_RP_NS, CLK_NS)), RC_C - RLOW_C - 2);
    localparam int REF_INT_C = imax(2, REF_WINDOW_NS / ROWS / CLK_NS);
    localparam int MAXC     = imax(imax(RCD_C, CAS_C), imax(imax(CP_C, REFLOW_C), RP_C));
    localparam int CNT_W    = $clog2(MAXC + 1);
    localparam int PG_W     = $clog2(PAGE_MAX) + 1;

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [PG_W-1:0]  pg;
        logic [AW-1:0]    row;
        logic [AW-1:0]    col;
        logic             wr;
        logic [DW-1:0]    wd;
        logic             ras_n;
        logic             cas_n;
        logic             we_n;
        logic             oe;
        logic [AW-1:0]    addr;
        logic             ack;
        logic [DW-1:0]    rd;
    } ctl_t;

    ctl_t q, d;
    logic ref_pend;
    logic ref_start;
    logic row_hit;
    logic pg_full;

    refresh_sched #(.INT_C(REF_INT_C)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (ref_start),
        .pend_o  (ref_pend)
    );

    row_hit_cmp #(.AW(AW)) u_hit (
        .open_row_i (q.row),
        .new_row_i  (host_addr[2*AW-1:AW]),
        .hit_o      (row_hit)
    );

    assign pg_full = (q.pg == PG_W'(PAGE_MAX - 1));

    always_comb begin
        d         = q;
        d.ack     = 1'b0;
        ref_start = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (ref_pend) begin
                    ref_start = 1'b1;
                    d.cas_n   = 1'b0;
                    d.st      = ST_REFC;
                end else if (host_req) begin
                    d.row  = host_addr[2*AW-1:AW];
                    d.col  = host_addr[AW-1:0];
                    d.wr   = host_we;
                    d.wd   = host_wdata;
                    d.pg   = '0;
                    d.addr = host_addr[2*AW-1:AW];
                    d.st   = ST_ROW;
                end
            end
            ST_ROW: begin
                d.ras_n = 1'b0;
                d.cnt   = CNT_W'(RCD_C - 1);
                d.st    = ST_RCD;
            end
            ST_RCD: begin
                if (q.cnt == '0) begin
                    d.addr = q.col;
                    d.we_n = ~q.wr;
                    d.oe   = q.wr;
                    d.st   = ST_COL;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_COL: begin
                d.cas_n = 1'b0;
                d.cnt   = CNT_W'(CAS_C - 1);
                d.st    = ST_CAS;
            end
            ST_CAS: begin
                if (q.cnt == '0) begin
                    d.ack   = 1'b1;
                    d.rd    = q.wr ? q.rd : dram_dq_in;
                    d.cas_n = 1'b1;
                    d.we_n  = 1'b1;
                    d.oe    = 1'b0;
                    d.cnt   = CNT_W'(CP_C - 1);
                    d.st    = ST_CPRE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_CPRE: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (host_req && row_hit && !ref_pend && !pg_full) begin
                    d.col  = host_addr[AW-1:0];
                    d.wr   = host_we;
                    d.wd   = host_wdata;
                    d.pg   = q.pg + 1'b1;
                    d.addr = host_addr[AW-1:0];
                    d.we_n = ~host_we;
                    d.oe   = host_we;
                    d.st   = ST_COL;
                end else begin
                    d.ras_n = 1'b1;
                    d.cnt   = CNT_W'(RP_C - 1);
                    d.st    = ST_PRE;
                end
            end
            ST_REFC: begin
                d.ras_n = 1'b0;
                d.cnt   = CNT_W'(REFLOW_C - 1);
                d.st    = ST_REFR;
            end
            ST_REFR: begin
                if (q.cnt == '0) begin
                    d.ras_n = 1'b1;
                    d.cas_n = 1'b1;
                    d.cnt   = CNT_W'(RP_C - 1);
                    d.st    = ST_PRE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_PRE: begin
                if (q.cnt == '0) d.st = ST_IDLE;
                else             d.cnt = q.cnt - 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.ras_n <= 1'b1;
            q.cas_n <= 1'b1;
            q.we_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign host_busy   = (q.st != ST_IDLE);
    assign host_ack    = q.ack;
    assign host_rdata  = q.rd;
    assign dram_addr   = q.addr;
    assign dram_ras_n  = q.ras_n;
    assign dram_cas_n  = q.cas_n;
    assign dram_we_n   = q.we_n;
    assign dram_dq_out = q.wd;
    assign dram_dq_oe  = q.oe;

    // ---------------- checks on the strobe timing ----------------
    localparam int RCW = $clog2(RC_C + 1) + 1;
    localparam int PCW = $clog2(PC_C + 1) + 1;
    localparam int PGC = $clog2(PAGE_MAX + 1) + 1;

    logic [RCW-1:0] rc_cnt_q;
    logic [PCW-1:0] pc_cnt_q;
    logic [PGC-1:0] col_in_row_q;
    logic           ras_prev_q, cas_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rc_cnt_q     <= RCW'(RC_C);
            pc_cnt_q     <= PCW'(PC_C);
            col_in_row_q <= '0;
            ras_prev_q   <= 1'b1;
            cas_prev_q   <= 1'b1;
        end else begin
            ras_prev_q <= dram_ras_n;
            cas_prev_q <= dram_cas_n;
            if (ras_prev_q && !dram_ras_n)      rc_cnt_q <= RCW'(1);
            else if (rc_cnt_q < RCW'(RC_C))     rc_cnt_q <= rc_cnt_q + 1'b1;
            if (cas_prev_q && !dram_cas_n)      pc_cnt_q <= PCW'(1);
            else if (pc_cnt_q < PCW'(PC_C))     pc_cnt_q <= pc_cnt_q + 1'b1;
            if (dram_ras_n)                     col_in_row_q <= '0;
            else if (cas_prev_q && !dram_cas_n) col_in_row_q <= col_in_row_q + 1'b1;
        end
    end

    assert_row_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && dram_cas_n) |-> $stable(dram_addr));

    assert_col_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_ras_n) |-> $stable(dram_addr));

    assert_early_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_ras_n) |-> $stable(dram_we_n));

    assert_oe_only_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (!dram_we_n && !dram_ras_n));

    assert_row_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (rc_cnt_q >= RCW'(RC_C)));

    assert_page_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> (pc_cnt_q >= PCW'(PC_C)));

    assert_cbr_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_cas_n) |-> ($past(!dram_cas_n) && dram_we_n));

    assert_page_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        col_in_row_q <= PGC'(PAGE_MAX));

    assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

endmodule

// File: tb/sim_dram_seq_ctrl.sv
module sim_dram_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int PAGE = 8;
    localparam int ROWS = 16;
    localparam int REF_WIN = 32000;
    // expected clock counts, from the requirements at a 10 ns clock
    localparam int RC_EXP  = 11;
    localparam int RP_EXP  = 5;
    localparam int PC_EXP  = 4;
    localparam int REF_EXP = 200;
    localparam int REF_SLACK = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic [7:0]    host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_busy, host_ack;
    logic [DW-1:0] host_rdata;
    logic [AW-1:0] dram_addr;
    logic          dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
    logic [DW-1:0] dram_dq_out;
    logic [DW-1:0] dram_dq_in = '0;

    dram_seq_ctrl #(
        .AW(AW), .DW(DW), .CLK_NS(CLK_PERIOD), .REF_WINDOW_NS(REF_WIN),
        .ROWS(ROWS), .PAGE_MAX(PAGE)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_busy(host_busy),
        .host_ack(host_ack), .host_rdata(host_rdata), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    function automatic void chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endfunction

    typedef struct {
        bit         rd;
        logic [7:0] exp;
    } sb_t;
    sb_t sbq[$];

    logic [7:0] mem [256];
    logic [7:0] shadow [256];

    // monitor state
    int  cyc = 0, last_ras_fall = -1, last_cas_fall = -1, ras_rise = -1, last_ref = -1;
    int  ref_cnt = 0, ras_fall_cnt = 0, cas_fall_cnt = 0, cas_in_row = 0;
    bit  ref_exact = 0;
    bit  prev_ras = 1, prev_cas = 1, prev_we = 1, prev_ack = 0;
    logic [AW-1:0] prev_addr = '0;
    logic [AW-1:0] m_row = '0;

    // memory model, timing monitor and scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (prev_ras && !dram_ras_n) begin
                if (!dram_cas_n) begin
                    chk(!prev_cas, "R8 cas before ras", prev_cas, 0);
                    chk(dram_we_n, "R8 we high in refresh", dram_we_n, 1);
                    if (last_ref >= 0) begin
                        chk(cyc - last_ref <= REF_EXP + REF_SLACK, "R9 refresh spacing",
                            cyc - last_ref, REF_EXP + REF_SLACK);
                        if (ref_exact)
                            chk(cyc - last_ref == REF_EXP, "R8 idle refresh period",
                                cyc - last_ref, REF_EXP);
                    end
                    last_ref = cyc;
                    ref_cnt++;
                end else begin
                    chk(dram_addr == host_addr[7:4], "R2 row address", dram_addr, host_addr[7:4]);
                    chk(dram_addr == prev_addr, "R2 row address setup", dram_addr, prev_addr);
                    m_row = dram_addr;
                    ras_fall_cnt++;
                end
                if (last_ras_fall >= 0)
                    chk(cyc - last_ras_fall >= RC_EXP, "R5 row cycle", cyc - last_ras_fall, RC_EXP);
                if (ras_rise >= 0)
                    chk(cyc - ras_rise >= RP_EXP, "R7 precharge", cyc - ras_rise, RP_EXP);
                last_ras_fall = cyc;
                cas_in_row = 0;
            end
            if (!prev_ras && dram_ras_n) ras_rise = cyc;
            if (prev_cas && !dram_cas_n && !dram_ras_n) begin
                chk(dram_addr == host_addr[3:0], "R2 column address", dram_addr, host_addr[3:0]);
                chk(dram_addr == prev_addr, "R2 column address setup", dram_addr, prev_addr);
                chk(dram_we_n == prev_we, "R4 we before cas", dram_we_n, prev_we);
                chk(dram_we_n == !host_we, "R4 we level", dram_we_n, !host_we);
                if (!dram_we_n) begin
                    chk(dram_dq_oe && dram_dq_out == host_wdata, "R4 write data",
                        dram_dq_out, host_wdata);
                    mem[{m_row, dram_addr}] = dram_dq_out;
                end else begin
                    dram_dq_in = mem[{m_row, dram_addr}];
                end
                if (last_cas_fall >= 0)
                    chk(cyc - last_cas_fall >= PC_EXP, "R6 page cycle", cyc - last_cas_fall, PC_EXP);
                last_cas_fall = cyc;
                cas_fall_cnt++;
                cas_in_row++;
                chk(cas_in_row <= PAGE, "R10 page limit", cas_in_row, PAGE);
            end
            if (dram_dq_oe) chk(!dram_we_n, "R4 oe only on write", dram_we_n, 0);
            if (host_ack) begin
                chk(!prev_ack, "R11 ack one clock", prev_ack, 0);
                if (sbq.size() == 0) begin
                    chk(0, "R11 unexpected ack", 1, 0);
                end else begin
                    sb_t e;
                    e = sbq.pop_front();
                    if (e.rd) chk(host_rdata == e.exp, "R3 read data", host_rdata, e.exp);
                end
            end
            prev_ras  = dram_ras_n;
            prev_cas  = dram_cas_n;
            prev_we   = dram_we_n;
            prev_ack  = host_ack;
            prev_addr = dram_addr;
        end
    end

    task automatic access(input bit we, input logic [7:0] a, input logic [7:0] wd, input bit keep);
        sb_t e;
        e.rd  = !we;
        e.exp = shadow[a];
        if (we) shadow[a] = wd;
        sbq.push_back(e);
        host_we    = we;
        host_addr  = a;
        host_wdata = wd;
        host_req   = 1'b1;
        do @(negedge clk); while (!host_ack);
        if (!keep) host_req = 1'b0;
    endtask

    task automatic wait_refresh();
        int r0;
        r0 = ref_cnt;
        while (ref_cnt == r0) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int r, c;
        for (int i = 0; i < 256; i++) begin
            mem[i]    = 8'(i) ^ 8'hA5;
            shadow[i] = 8'(i) ^ 8'hA5;
        end
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(dram_ras_n, "R1 ras_n", dram_ras_n, 1);
        chk(dram_cas_n, "R1 cas_n", dram_cas_n, 1);
        chk(dram_we_n, "R1 we_n", dram_we_n, 1);
        chk(!dram_dq_oe, "R1 dq_oe", dram_dq_oe, 0);
        chk(!host_ack, "R1 ack", host_ack, 0);
        chk(!host_busy, "R1 busy", host_busy, 0);
        rst_n = 1'b1;

        // single accesses (R2 R3 R4)
        wait_refresh();
        access(1, 8'h35, 8'h5C, 0);
        repeat (3) @(negedge clk);
        chk(mem[8'h35] == 8'h5C, "R4 stored write", mem[8'h35], 8'h5C);
        access(0, 8'h35, 8'h00, 0);
        access(0, 8'h12, 8'h00, 0);

        // R6 page bursts
        wait_refresh();
        r = ras_fall_cnt; c = cas_fall_cnt;
        for (int i = 0; i < 4; i++) access(1, 8'h70 + 8'(i), 8'h10 + 8'(i), i != 3);
        repeat (10) @(negedge clk);
        chk(ras_fall_cnt - r == 1, "R6 one row opening for write burst", ras_fall_cnt - r, 1);
        chk(cas_fall_cnt - c == 4, "R6 column strobes in burst", cas_fall_cnt - c, 4);
        r = ras_fall_cnt;
        for (int i = 3; i >= 0; i--) access(0, 8'h70 + 8'(i), 8'h00, i != 0);
        repeat (10) @(negedge clk);
        chk(ras_fall_cnt - r == 1, "R6 one row opening for read burst", ras_fall_cnt - r, 1);

        // R7 row changes within a held request
        wait_refresh();
        r = ras_fall_cnt;
        access(1, 8'h21, 8'hC1, 1);
        access(1, 8'h91, 8'hC2, 1);
        access(1, 8'h22, 8'hC3, 0);
        repeat (10) @(negedge clk);
        chk(ras_fall_cnt - r == 3, "R7 row reopened per row change", ras_fall_cnt - r, 3);
        access(0, 8'h91, 8'h00, 1);
        access(0, 8'h21, 8'h00, 1);
        access(0, 8'h22, 8'h00, 0);

        // R10 page limit
        wait_refresh();
        r = ras_fall_cnt; c = cas_fall_cnt;
        for (int i = 0; i < 10; i++) access(0, 8'h50 + 8'(i), 8'h00, i != 9);
        repeat (10) @(negedge clk);
        chk(ras_fall_cnt - r == 2, "R10 burst split at limit", ras_fall_cnt - r, 2);
        chk(cas_fall_cnt - c == 10, "R10 all columns served", cas_fall_cnt - c, 10);

        // R8 idle refresh cadence
        wait_refresh();
        ref_exact = 1;
        r = ref_cnt;
        repeat (1000) @(negedge clk);
        chk(ref_cnt - r == 5, "R8 refresh count over five periods", ref_cnt - r, 5);
        ref_exact = 0;

        // R9 refresh under sustained page traffic
        r = ref_cnt;
        for (int i = 0; i < 80; i++) access(i % 3 == 0, 8'hA0 + 8'(i % 16), 8'(i), i != 79);
        repeat (10) @(negedge clk);
        chk(ref_cnt - r >= 1, "R9 refresh served during traffic", ref_cnt - r, 1);

        access(0, 8'h72, 8'h00, 0);
        access(0, 8'h35, 8'h00, 0);
        repeat (5) @(negedge clk);
        chk(sbq.size() == 0, "R11 every request acknowledged", sbq.size(), 0);
        summary();
        $finish;
    end

endmodule